// File: doc/BRIEF.md
# String Transfer Length Predictor

This block guesses how many bytes a variable-length string load or store will move, so that the decoder can crack the instruction into a fixed micro-op sequence before the length register is known. It keeps a direct-mapped table, indexed by instruction address bits, that remembers the byte count seen the last time that instruction completed. Each entry also stores a short address tag, so two instructions that share a slot show up as a miss rather than as a wrong guess.

The decoder presents an address on the lookup side and gets back a hit flag and a length in the same cycle. When the instruction resolves, the update side receives the address, the true byte count, a flag marking a variable-length operation, and the prediction that decode actually used. A guess that turns out wrong raises a one-cycle mispredict pulse, which starts recovery elsewhere. The same update rewrites the entry with the true count. Fixed-length memory operations and out-of-range counts never touch the table.

Top module: `lenpred_top`

## Requirements
- R1: After reset every lookup misses: `lk_hit` is 0 and `lk_len` is 0.
- R2: A lookup is combinational. If the entry selected by address bits [9:2] is valid and its stored tag equals address bits [15:10], it returns `lk_hit`=1 and the stored length.
- R3: A lookup whose slot holds a different tag misses. A variable-length update to that slot replaces the tag, so the earlier address then misses.
- R4: An update with `upd_varlen`=0 changes no entry and never raises `mispredict`.
- R5: An accepted update with `upd_pred_hit`=1 and `upd_pred_len` different from `upd_len` sets `mispredict` on the next cycle. An accepted update is one with `upd_valid`=1, `upd_varlen`=1 and `upd_len`≤128.
- R6: `mispredict` lasts exactly one cycle per offending update. It is 0 when the prediction matched or when `upd_pred_hit`=0.
- R7: An accepted update writes the true length into the entry, and the entry is valid from the next cycle on.
- R8: Lengths 0 through 128 are stored. An update with `upd_len` above 128 changes no entry and raises no `mispredict`.
- R9: When a lookup and an update address the same entry in the same cycle, the lookup returns the contents from before that update.
- R10: A miss always reports `lk_len`=0, and a reported length never exceeds 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | 32 | Address of the instruction being decoded |
| lk_hit | output | 1 | Lookup found a valid entry with a matching tag |
| lk_len | output | 8 | Predicted byte count (0 on a miss) |
| upd_valid | input | 1 | A resolved memory operation is reported this cycle |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_len | input | 8 | True byte count |
| upd_varlen | input | 1 | The operation has a register-defined length |
| upd_pred_hit | input | 1 | Decode used a prediction for this instance |
| upd_pred_len | input | 8 | Length decode used for this instance |
| mispredict | output | 1 | One-cycle pulse after a wrong prediction |

## Verification
The hardest case to reach is a lookup and an update that meet on one slot in one cycle, especially when the update changes the tag or the length. A lookup sent the cycle after would show the new contents and hide the ordering. The bench sends both in one step, with the same address or with an alias that differs only above bit 9. Then it sends a random phase over a small address set that collides on purpose. In that phase the prediction handed back on update is usually what the table last returned, sometimes perturbed, so matches, mispredicts and misses all occur next to each other.

// File: rtl/lenpred_pkg.sv
package lenpred_pkg;

   // Classification of an incoming update
   typedef enum logic [1:0] {
      UPD_IDLE   = 2'd0,
      UPD_TRAIN  = 2'd1,
      UPD_REJECT = 2'd2
   } upd_kind_e;

   function automatic logic len_fits(input logic [15:0] len, input int unsigned max_len);
      return (32'(len) <= max_len);
   endfunction

endpackage

// File: rtl/lenpred_index.sv
module lenpred_index #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned IDX_LSB = 2,
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned TAG_W   = 6,
   localparam int unsigned TS     = (TAG_W > 0) ? TAG_W : 1
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx,
   output logic [TS-1:0]    tag
);

   assign idx = IDX_W'(pc >> IDX_LSB);

   generate
      if (TAG_W > 0) begin : g_tagged
         assign tag = TS'(pc >> (IDX_LSB + IDX_W));
      end else begin : g_untagged
         assign tag = '0;
      end
   endgenerate

endmodule

// File: rtl/lenpred_qualify.sv
module lenpred_qualify
   import lenpred_pkg::*;
#(
   parameter int unsigned LEN_W   = 8,
   parameter int unsigned MAX_LEN = 128
) (
   input  logic             upd_valid,
   input  logic             upd_varlen,
   input  logic [LEN_W-1:0] upd_len,
   input  logic             pred_hit,
   input  logic [LEN_W-1:0] pred_len,
   output upd_kind_e        kind,
   output logic             wr_en,
   output logic             wrong_now
);

   logic in_range;

   assign in_range = len_fits(16'(upd_len), MAX_LEN);

   always_comb begin
      kind = UPD_IDLE;
      if (upd_valid && upd_varlen) begin
         kind = in_range ? UPD_TRAIN : UPD_REJECT;
      end
   end

   assign wr_en     = (kind == UPD_TRAIN);
   assign wrong_now = wr_en && pred_hit && (pred_len != upd_len);

endmodule

// File: rtl/lenpred_table.sv
module lenpred_table #(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned TAG_W = 6,
   parameter int unsigned LEN_W = 8,
   localparam int unsigned DEPTH = 1 << IDX_W,
   localparam int unsigned TS    = (TAG_W > 0) ? TAG_W : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TS-1:0]    rd_tag,
   output logic             rd_hit,
   output logic [LEN_W-1:0] rd_len,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TS-1:0]    wr_tag,
   input  logic [LEN_W-1:0] wr_len
);

   logic [DEPTH-1:0] vld_q;
   logic [LEN_W-1:0] len_q [DEPTH];
   logic             tag_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         len_q[wr_idx] <= wr_len;
      end
   end

   generate
      if (TAG_W > 0) begin : g_tag_store
         logic [TS-1:0] tag_q [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_en) begin
               tag_q[wr_idx] <= wr_tag;
            end
         end
         assign tag_ok = (tag_q[rd_idx] == rd_tag);
      end else begin : g_no_tag
         logic unused_tag;
         assign unused_tag = ^{rd_tag, wr_tag};
         assign tag_ok = 1'b1;
      end
   endgenerate

   assign rd_hit = vld_q[rd_idx] && tag_ok;
   assign rd_len = rd_hit ? len_q[rd_idx] : '0;

endmodule

// File: rtl/lenpred_flag.sv
module lenpred_flag (
   input  logic clk,
   input  logic rst,
   input  logic set_now,
   output logic pulse
);

   always_ff @(posedge clk) begin
      if (rst) begin
         pulse <= 1'b0;
      end else begin
         pulse <= set_now;
      end
   end

endmodule

// File: rtl/lenpred_top.sv
module lenpred_top
   import lenpred_pkg::*;
#(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned IDX_LSB = 2,
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned TAG_W   = 6,
   parameter int unsigned LEN_W   = 8,
   parameter int unsigned MAX_LEN = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PC_W-1:0]  lk_pc,
   output logic             lk_hit,
   output logic [LEN_W-1:0] lk_len,
   input  logic             upd_valid,
   input  logic [PC_W-1:0]  upd_pc,
   input  logic [LEN_W-1:0] upd_len,
   input  logic             upd_varlen,
   input  logic             upd_pred_hit,
   input  logic [LEN_W-1:0] upd_pred_len,
   output logic             mispredict
);

   localparam int unsigned TS = (TAG_W > 0) ? TAG_W : 1;

   // Elaboration-time parameter checks
   generate
      if (IDX_LSB + IDX_W + TAG_W > PC_W) begin : g_bad_split
         $error("lenpred_top: index and tag exceed the address width");
      end
      if (MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
         $error("lenpred_top: MAX_LEN does not fit LEN_W");
      end
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_depth
         $error("lenpred_top: IDX_W out of supported range");
      end
   endgenerate

   logic [IDX_W-1:0] lk_idx, up_idx;
   logic [TS-1:0]    lk_tag, up_tag;
   upd_kind_e        kind;
   logic             wr_en, wrong_now;

   lenpred_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_index (
      .pc (lk_pc),
      .idx(lk_idx),
      .tag(lk_tag)
   );

   lenpred_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_up_index (
      .pc (upd_pc),
      .idx(up_idx),
      .tag(up_tag)
   );

   lenpred_qualify #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_qualify (
      .upd_valid(upd_valid),
      .upd_varlen(upd_varlen),
      .upd_len(upd_len),
      .pred_hit(upd_pred_hit),
      .pred_len(upd_pred_len),
      .kind(kind),
      .wr_en(wr_en),
      .wrong_now(wrong_now)
   );

   lenpred_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LEN_W(LEN_W)) u_table (
      .clk(clk),
      .rst(rst),
      .rd_idx(lk_idx),
      .rd_tag(lk_tag),
      .rd_hit(lk_hit),
      .rd_len(lk_len),
      .wr_en(wr_en),
      .wr_idx(up_idx),
      .wr_tag(up_tag),
      .wr_len(upd_len)
   );

   lenpred_flag u_flag (
      .clk(clk),
      .rst(rst),
      .set_now(wrong_now),
      .pulse(mispredict)
   );

endmodule

// File: rtl/lenpred_top_chk.sv
module lenpred_top_chk #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned LEN_W   = 8,
   parameter int unsigned MAX_LEN = 128
) (
   input logic             clk,
   input logic             rst,
   input logic [PC_W-1:0]  lk_pc,
   input logic             lk_hit,
   input logic [LEN_W-1:0] lk_len,
   input logic             upd_valid,
   input logic [PC_W-1:0]  upd_pc,
   input logic [LEN_W-1:0] upd_len,
   input logic             upd_varlen,
   input logic             upd_pred_hit,
   input logic [LEN_W-1:0] upd_pred_len,
   input logic             mispredict
);

   logic accepted;
   assign accepted = upd_valid && upd_varlen && (32'(upd_len) <= MAX_LEN);

   // R10
   miss_len_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !lk_hit |-> (lk_len == '0));

   // R10
   len_bound_chk: assert property (@(posedge clk) disable iff (rst)
      32'(lk_len) <= MAX_LEN);

   // R5
   wrong_guess_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (accepted && upd_pred_hit && (upd_pred_len != upd_len)) |=> mispredict);

   // R4
   fixed_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
      mispredict |-> $past(accepted));

   // R6
   right_guess_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!accepted || !upd_pred_hit || (upd_pred_len == upd_len)) |=> !mispredict);

   // R7
   learned_next_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(accepted) && (lk_pc == $past(upd_pc))) |-> (lk_hit && (lk_len == $past(upd_len))));

endmodule

bind lenpred_top lenpred_top_chk #(.PC_W(PC_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
   .clk(clk),
   .rst(rst),
   .lk_pc(lk_pc),
   .lk_hit(lk_hit),
   .lk_len(lk_len),
   .upd_valid(upd_valid),
   .upd_pc(upd_pc),
   .upd_len(upd_len),
   .upd_varlen(upd_varlen),
   .upd_pred_hit(upd_pred_hit),
   .upd_pred_len(upd_pred_len),
   .mispredict(mispredict)
);

// File: tb/lenpred_top_test.sv
`timescale 1ns/1ps
module lenpred_top_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] lk_pc = '0;
   logic        lk_hit;
   logic [7:0]  lk_len;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic [7:0]  upd_len = '0;
   logic        upd_varlen = 1'b0;
   logic        upd_pred_hit = 1'b0;
   logic [7:0]  upd_pred_len = '0;
   logic        mispredict;

   int compared = 0;
   int mismatched = 0;

   // reference state
   int m_vld [256];
   int m_tag [256];
   int m_len [256];
   int exp_mis = 0;

   always #4 clk = ~clk;

   lenpred_top uut (
      .clk(clk), .rst(rst),
      .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_len(lk_len),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_len(upd_len),
      .upd_varlen(upd_varlen), .upd_pred_hit(upd_pred_hit),
      .upd_pred_len(upd_pred_len), .mispredict(mispredict)
   );

   function automatic int ix(input logic [31:0] pc);
      return int'(pc[9:2]);
   endfunction

   function automatic int tg(input logic [31:0] pc);
      return int'(pc[15:10]);
   endfunction

   function automatic int ref_hit(input logic [31:0] pc);
      return (m_vld[ix(pc)] != 0 && m_tag[ix(pc)] == tg(pc)) ? 1 : 0;
   endfunction

   function automatic int ref_len(input logic [31:0] pc);
      return ref_hit(pc) ? m_len[ix(pc)] : 0;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // One cycle: drive, compare lookup and pending pulse, advance model, clock.
   task automatic step(input string req, input logic [31:0] lpc,
                       input logic uv, input logic [31:0] upc, input int ulen,
                       input logic uvar, input logic phit, input int plen);
      int nxt;
      lk_pc = lpc;
      upd_valid = uv;
      upd_pc = upc;
      upd_len = 8'(ulen);
      upd_varlen = uvar;
      upd_pred_hit = phit;
      upd_pred_len = 8'(plen);
      #1;
      check(req, "lk_hit", int'(lk_hit), ref_hit(lpc));
      check(req, "lk_len", int'(lk_len), ref_len(lpc));
      check(req, "mispredict", int'(mispredict), exp_mis);
      nxt = 0;
      if (uv && uvar && ulen <= 128) begin
         nxt = (phit && plen != ulen) ? 1 : 0;
         m_vld[ix(upc)] = 1;
         m_tag[ix(upc)] = tg(upc);
         m_len[ix(upc)] = ulen;
      end
      exp_mis = nxt;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic look(input string req, input logic [31:0] lpc);
      step(req, lpc, 1'b0, 32'h0, 0, 1'b0, 1'b0, 0);
   endtask

   initial begin
      #(8 * 200000);
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [31:0] a, alias_a, b;
      for (int i = 0; i < 256; i++) begin
         m_vld[i] = 0; m_tag[i] = 0; m_len[i] = 0;
      end
      a = 32'h0000_1240;
      alias_a = a + 32'h400;
      b = 32'h0000_2088;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: empty after reset
      for (int i = 0; i < 6; i++) look("R1", 32'h100 * i + 32'h4 * i);

      // R2 / R7: train then hit
      step("R7", a, 1'b1, a, 37, 1'b1, 1'b0, 0);
      look("R2", a);

      // R3: alias misses, then alias takes slot
      look("R3", alias_a);
      step("R3", alias_a, 1'b1, alias_a, 12, 1'b1, 1'b0, 0);
      look("R3", a);
      look("R3", alias_a);
      step("R7", a, 1'b1, a, 37, 1'b1, 1'b0, 0);

      // R4: fixed-length updates ignored
      step("R4", b, 1'b1, b, 20, 1'b0, 1'b1, 3);
      look("R4", b);
      step("R4", a, 1'b1, a, 90, 1'b0, 1'b1, 37);
      look("R4", a);

      // R5 / R6: wrong guess, one-cycle pulse, overwrite
      step("R5", a, 1'b1, a, 50, 1'b1, 1'b1, 37);
      look("R5", a);
      look("R6", a);
      // R6: matching guess and unpredicted instance stay quiet
      step("R6", a, 1'b1, a, 50, 1'b1, 1'b1, 50);
      look("R6", a);
      step("R6", b, 1'b1, b, 64, 1'b1, 1'b0, 9);
      look("R6", b);
      // R5: back-to-back wrong guesses give back-to-back pulses
      step("R5", a, 1'b1, a, 51, 1'b1, 1'b1, 50);
      step("R5", a, 1'b1, a, 52, 1'b1, 1'b1, 50);
      look("R5", a);

      // R8: range limits
      step("R8", b, 1'b1, b, 0, 1'b1, 1'b1, 64);
      look("R8", b);
      step("R8", b, 1'b1, b, 128, 1'b1, 1'b1, 0);
      look("R8", b);
      step("R8", b, 1'b1, b, 129, 1'b1, 1'b1, 128);
      look("R8", b);
      step("R8", b, 1'b1, b, 255, 1'b1, 1'b1, 128);
      look("R8", b);

      // R9: same-cycle lookup and update
      step("R9", a, 1'b1, a, 77, 1'b1, 1'b1, 52);
      look("R9", a);
      step("R9", a, 1'b1, alias_a, 5, 1'b1, 1'b0, 0);
      look("R9", a);
      look("R9", alias_a);

      // R10 and mixed traffic
      for (int n = 0; n < 400; n++) begin
         logic [31:0] p, q;
         int l, pl;
         logic ph;
         p = {16'h0, 6'($urandom_range(0, 3)), 8'($urandom_range(0, 3)), 2'b00};
         q = {16'h0, 6'($urandom_range(0, 3)), 8'($urandom_range(0, 3)), 2'b00};
         l = $urandom_range(0, 140);
         ph = 1'(ref_hit(q));
         pl = ref_len(q);
         if ($urandom_range(0, 3) == 0) pl = $urandom_range(0, 128);
         if ($urandom_range(0, 3) == 0) l = pl;
         step("R10", p, 1'($urandom_range(0, 4) != 0), q, l,
              1'($urandom_range(0, 5) != 0), ph, pl);
      end
      look("R10", 32'h0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule